// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Queued Break and Idle Preamble

This block turns characters from a one-entry data buffer into an asynchronous serial stream on a single output line. A character goes out as a low start bit, eight or nine data bits least significant first, and a high stop bit. Each bit lasts one interval of an external baud tick. A shift register carries the character on the line while the next character waits in the buffer.

Besides data, the transmitter sends two special characters. A break holds the line low for a whole character time. An idle preamble holds it high for a whole character time. A rising edge on the send-break control queues a break, and breaks keep coming for as long as that control stays high. A rising edge on the transmitter enable queues a preamble. Software sees two flags: buffer empty and transmission complete. Each flag is cleared by a two-step sequence: a status read that finds the flag set, then a qualifying action.

The data path has no valid/ready pair. Buffer empty is the readiness indication, and the status-read handshake is the only back-pressure. A data write always replaces the buffer contents. The character is committed for sending only when the write follows a status read that saw buffer empty set. A write made without that read does not send the stored value.

Top module: `utx_break_tx`

## Requirements
- R1: While reset is held and right after it, `tx_o` is 1, `buf_empty` is 1 and `tx_done` is 1.
- R2: A data character is a start bit of 0, then the data bits least significant first, then a stop bit of 1, each held for one baud tick interval. `nine_bit`=0 sends bits [7:0] of `dr_wdata` in 10 intervals; `nine_bit`=1 sends bits [8:0] in 11 intervals.
- R3: `buf_empty` falls one cycle after a `dr_wr` that follows an `sr_rd` which saw it at 1. A `dr_wr` without such a read stores the value, leaves `buf_empty` at 1 and sends nothing.
- R4: `buf_empty` returns to 1 on the baud tick that moves the buffered character into the shifter, that is, when its start bit begins.
- R5: `tx_done` is set while the buffer is empty and no character of any kind is on the line. After an `sr_rd` that saw it at 1, it is cleared by a `dr_wr`, a 0-to-1 change of `tx_en`, or a 0-to-1 change of `brk_req`.
- R6: A status read arms the clear only for a flag it saw at 1. If the flag was 0 at the read and is set later, the following action leaves it at 1.
- R7: A 0-to-1 change of `brk_req` queues one break: `tx_o` at 0 for 10 intervals (11 when `nine_bit`=1). This happens even if `brk_req` returns to 0 before the break starts.
- R8: While `brk_req` stays 1, another break is loaded each time the previous character ends. Holding it high for 15 intervals gives two back-to-back breaks, 20 low intervals.
- R9: A 0-to-1 change of `tx_en` queues a preamble: `tx_o` at 1 for one character length. Pending characters start in this order: preamble, then break, then buffered data.
- R10: While `tx_en` is 0, `tx_o` is 1 and no character starts. Queued data and breaks stay pending until enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse that marks each bit interval boundary |
| tx_en | input | 1 | Transmitter enable; a rising edge queues a preamble |
| brk_req | input | 1 | Send-break control; a rising edge queues a break, holding it repeats breaks |
| nine_bit | input | 1 | 1 selects nine data bits per character |
| dr_wr | input | 1 | Data register write strobe |
| dr_wdata | input | DATA_W+1 | Data written to the buffer |
| sr_rd | input | 1 | Status register read strobe; arms flag clears |
| tx_o | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Data buffer empty flag |
| tx_done | output | 1 | Transmission complete flag |

## Verification
The assertions assume that `baud_tick` is a one-cycle pulse and that strobes are single-cycle events. They also assume a status read happens at least one cycle before the action it arms, and that `tx_en` stays high for the cycle after a character is loaded. The bench produces a tick every four cycles and drives every strobe for exactly one cycle, on the falling edge just after a tick. It separates each read from the write, break or enable change that follows it by one or more cycles. So every pulse and every load lands in a known bit interval, and no load coincides with the tick that would split a bit.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_PRE  = 2'd1,
    LD_BRK  = 2'd2,
    LD_DATA = 2'd3
  } load_kind_e;
endpackage

// File: rtl/utx_flags.sv
module utx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic sr_rd_i,
  input  logic dr_wr_i,
  input  logic xfer_i,
  input  logic tc_act_i,
  input  logic idle_i,
  output logic tdre_o,
  output logic tc_o
);
  logic tdre_arm, tc_arm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tdre_o   <= 1'b1;
      tc_o     <= 1'b1;
      tdre_arm <= 1'b0;
      tc_arm   <= 1'b0;
    end else begin
      if (xfer_i)                   tdre_o <= 1'b1;
      else if (dr_wr_i && tdre_arm) tdre_o <= 1'b0;

      if (dr_wr_i)                  tdre_arm <= 1'b0;
      else if (sr_rd_i && tdre_o)   tdre_arm <= 1'b1;

      if (tc_act_i && tc_arm)       tc_o <= 1'b0;
      else if (idle_i)              tc_o <= 1'b1;

      if (tc_act_i)                 tc_arm <= 1'b0;
      else if (sr_rd_i && tc_o)     tc_arm <= 1'b1;
    end
  end

  // R3: the empty flag only drops right after a data write
  a_r3_tdre_fall_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tdre_o) |-> $past(dr_wr_i));
  // R6: the empty flag only drops when a read that saw it set came first
  a_r6_tdre_fall_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tdre_o) |-> $past(tdre_arm));
  // R4: the empty flag only rises when a character enters the shifter
  a_r4_tdre_rise_on_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tdre_o) |-> $past(xfer_i));
  // R5: transmit-complete only drops after an armed action
  a_r5_tc_fall_on_action: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tc_o) |-> ($past(tc_act_i) && $past(tc_arm)));
endmodule

// File: rtl/utx_queue.sv
module utx_queue
  import utx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       te_i,
  input  logic       brk_i,
  input  logic       slot_i,
  input  logic       tdre_i,
  output load_kind_e kind_o,
  output logic       pre_rise_o,
  output logic       brk_rise_o,
  output logic       pend_o
);
  logic te_q, brk_q, pre_pend, brk_pend;
  logic pre_now, brk_now;

  assign pre_rise_o = te_i & ~te_q;
  assign brk_rise_o = brk_i & ~brk_q;
  assign pre_now    = pre_pend | pre_rise_o;
  assign brk_now    = brk_pend | brk_i;
  assign pend_o     = pre_pend | brk_pend | brk_i;

  always_comb begin
    if (pre_now)      kind_o = LD_PRE;
    else if (brk_now) kind_o = LD_BRK;
    else if (!tdre_i) kind_o = LD_DATA;
    else              kind_o = LD_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      te_q     <= 1'b0;
      brk_q    <= 1'b0;
      pre_pend <= 1'b0;
      brk_pend <= 1'b0;
    end else begin
      te_q  <= te_i;
      brk_q <= brk_i;
      if (slot_i && kind_o == LD_PRE) pre_pend <= 1'b0;
      else if (pre_rise_o)            pre_pend <= 1'b1;
      if (slot_i && kind_o == LD_BRK) brk_pend <= 1'b0;
      else if (brk_rise_o)            brk_pend <= 1'b1;
    end
  end

  // R9: buffered data never starts ahead of a pending preamble or break
  a_r9_data_last: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && kind_o == LD_DATA) |-> (!pre_pend && !brk_pend));
  // R7: a queued break stays pending until a slot consumes it
  a_r7_break_held: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_pend && !slot_i) |=> brk_pend);
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import utx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              nine_i,
  input  load_kind_e        kind_i,
  input  logic [DATA_W:0]   data_i,
  output logic              slot_o,
  output logic              busy_o,
  output logic              tx_o
);
  localparam int FRAME_MAX = DATA_W + 3;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(DATA_W + 3);

  logic [FRAME_MAX-1:0] shreg, frame;
  logic [CNT_W-1:0]     cnt, len;

  assign len    = nine_i ? LEN_LONG : LEN_SHORT;
  assign slot_o = en_i & tick_i & (~busy_o | (cnt == CNT_W'(1)));
  assign tx_o   = (busy_o & en_i) ? shreg[0] : 1'b1;

  always_comb begin
    frame = '1;
    unique case (kind_i)
      LD_BRK: frame = '0;
      LD_DATA: begin
        frame[0]        = 1'b0;
        frame[DATA_W:1] = data_i[DATA_W-1:0];
        if (nine_i) frame[DATA_W+1] = data_i[DATA_W];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt    <= '0;
      shreg  <= '1;
    end else if (!en_i) begin
      busy_o <= 1'b0;
      shreg  <= '1;
    end else if (slot_o && kind_i != LD_NONE) begin
      busy_o <= 1'b1;
      cnt    <= len;
      shreg  <= frame;
    end else if (tick_i && busy_o) begin
      if (cnt == CNT_W'(1)) busy_o <= 1'b0;
      else                  cnt    <= cnt - CNT_W'(1);
      shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
    end
  end

  // R2: the bit counter stays inside one character while busy
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt != '0 && cnt <= CNT_W'(FRAME_MAX)));
  // R2: a data load puts the start bit on the line next cycle
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_o && kind_i == LD_DATA) |=> (!tx_o || !en_i));
  // R7: a break load drives the line low next cycle
  a_r7_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_o && kind_i == LD_BRK) |=> (!tx_o || !en_i));
  // R9: a preamble keeps the line high
  a_r9_preamble_high: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_o && kind_i == LD_PRE) |=> tx_o);
endmodule

// File: rtl/utx_break_tx.sv
module utx_break_tx
  import utx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              brk_req,
  input  logic              nine_bit,
  input  logic              dr_wr,
  input  logic [DATA_W:0]   dr_wdata,
  input  logic              sr_rd,
  output logic              tx_o,
  output logic              buf_empty,
  output logic              tx_done
);
  logic [DATA_W:0] dbuf;
  load_kind_e      kind;
  logic            slot, busy, pre_rise, brk_rise, pend;
  logic            xfer, tc_act, idle_now;

  always_ff @(posedge clk) begin
    if (!rst_n)     dbuf <= '0;
    else if (dr_wr) dbuf <= dr_wdata;
  end

  assign xfer     = slot & (kind == LD_DATA);
  assign tc_act   = dr_wr | pre_rise | brk_rise;
  assign idle_now = buf_empty & ~busy & ~pend;

  utx_queue u_queue (
    .clk(clk), .rst_n(rst_n), .te_i(tx_en), .brk_i(brk_req),
    .slot_i(slot), .tdre_i(buf_empty), .kind_o(kind),
    .pre_rise_o(pre_rise), .brk_rise_o(brk_rise), .pend_o(pend)
  );

  utx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick_i(baud_tick), .en_i(tx_en),
    .nine_i(nine_bit), .kind_i(kind), .data_i(dbuf),
    .slot_o(slot), .busy_o(busy), .tx_o(tx_o)
  );

  utx_flags u_flags (
    .clk(clk), .rst_n(rst_n), .sr_rd_i(sr_rd), .dr_wr_i(dr_wr),
    .xfer_i(xfer), .tc_act_i(tc_act), .idle_i(idle_now),
    .tdre_o(buf_empty), .tc_o(tx_done)
  );

  // R10: the line is high whenever the transmitter is disabled
  a_r10_disabled_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> tx_o);
  // R5: transmit-complete is never set while a character is on the line
  a_r5_done_not_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_done)) |-> $past(!busy));
endmodule

// File: tb/utx_break_tx_bench.sv
module utx_break_tx_bench;
  localparam int DATA_W = 8;
  localparam int TP     = 4;

  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, tx_en = 1'b0;
  logic brk_req = 1'b0, nine_bit = 1'b0, dr_wr = 1'b0, sr_rd = 1'b0;
  logic [DATA_W:0] dr_wdata = '0;
  logic tx_o, buf_empty, tx_done;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  utx_break_tx #(.DATA_W(DATA_W)) u_utx_break_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .brk_req(brk_req), .nine_bit(nine_bit), .dr_wr(dr_wr),
    .dr_wdata(dr_wdata), .sr_rd(sr_rd), .tx_o(tx_o),
    .buf_empty(buf_empty), .tx_done(tx_done)
  );

  always #4 clk = ~clk;

  initial begin : tick_gen
    int c = 0;
    forever begin
      @(negedge clk);
      c = c + 1;
      baud_tick = (c % TP == 0);
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sample_bit(output logic b);
    do @(posedge clk); while (!baud_tick);
    @(negedge clk);
    b = tx_o;
  endtask

  task automatic align();
    logic b;
    sample_bit(b);
  endtask

  task automatic collect(input int n, output logic [31:0] bits);
    bits = '1;
    for (int i = 0; i < n; i++) begin
      logic b;
      sample_bit(b);
      bits[i] = b;
    end
  endtask

  task automatic pulse_rd();
    sr_rd = 1'b1; @(negedge clk); sr_rd = 1'b0;
  endtask

  task automatic pulse_wr(input logic [DATA_W:0] v);
    dr_wdata = v; dr_wr = 1'b1; @(negedge clk); dr_wr = 1'b0;
  endtask

  task automatic pulse_brk();
    brk_req = 1'b1; @(negedge clk); brk_req = 1'b0;
  endtask

  function automatic logic [31:0] exp_frame(input logic [DATA_W:0] d, input bit nine);
    int nd = nine ? DATA_W + 1 : DATA_W;
    logic [31:0] f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < nd; i++) f[i+1] = d[i];
    return f;
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(tx_o == 1'b1 && buf_empty && tx_done, "R1 during reset", {tx_o, buf_empty, tx_done}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_o == 1'b1 && buf_empty && tx_done, "R1 after reset", {tx_o, buf_empty, tx_done}, 3'b111);
    align();
    tx_en = 1'b1;
    begin
      logic [31:0] b;
      collect(14, b);
      check(b[13:0] == 14'h3fff, "R9 start-up preamble high", b[13:0], 14'h3fff);
    end
  endtask

  task automatic t_unarmed_write();
    logic [31:0] b;
    align();
    pulse_wr(9'h03C);
    check(buf_empty == 1'b1, "R3 write without read keeps empty", buf_empty, 1);
    collect(14, b);
    check(b[13:0] == 14'h3fff, "R3 write without read sends nothing", b[13:0], 14'h3fff);
  endtask

  task automatic t_send8();
    logic [31:0] b, e;
    logic s;
    align();
    pulse_rd();
    pulse_wr(9'h0A5);
    check(buf_empty == 1'b0, "R3 armed write clears empty", buf_empty, 0);
    check(tx_done == 1'b0, "R5 armed write clears done", tx_done, 0);
    sample_bit(s);
    check(buf_empty == 1'b1, "R4 empty set at transfer", buf_empty, 1);
    collect(9, b);
    b = {b[30:0], s};
    e = exp_frame(9'h0A5, 1'b0);
    check(b[9:0] == e[9:0], "R2 8-bit frame", b[9:0], e[9:0]);
    collect(2, b);
    check(tx_done == 1'b1, "R5 done set after frame", tx_done, 1);
  endtask

  task automatic t_send9();
    logic [31:0] b, e;
    align();
    nine_bit = 1'b1;
    pulse_rd();
    pulse_wr(9'h15A);
    collect(11, b);
    e = exp_frame(9'h15A, 1'b1);
    check(b[10:0] == e[10:0], "R2 9-bit frame", b[10:0], e[10:0]);
    collect(2, b);
    nine_bit = 1'b0;
  endtask

  task automatic t_arm_rule();
    logic [31:0] b, e;
    logic s;
    align();
    pulse_rd();
    pulse_wr(9'h03E);
    check(buf_empty == 1'b0, "R3 empty cleared for first char", buf_empty, 0);
    pulse_rd();
    sample_bit(s);
    check(buf_empty == 1'b1, "R4 empty set at start bit", buf_empty, 1);
    pulse_wr(9'h055);
    check(buf_empty == 1'b1, "R6 stale read does not arm clear", buf_empty, 1);
    collect(9, b);
    b = {b[30:0], s};
    e = exp_frame(9'h03E, 1'b0);
    check(b[9:0] == e[9:0], "R6 first char intact", b[9:0], e[9:0]);
    collect(12, b);
    check(b[11:0] == 12'hfff, "R6 second char not sent", b[11:0], 12'hfff);
  endtask

  task automatic t_break_single();
    logic [31:0] b;
    align();
    pulse_rd();
    pulse_brk();
    check(tx_done == 1'b0, "R5 armed break clears done", tx_done, 0);
    collect(14, b);
    check(b[13:0] == 14'h3c00, "R7 one break of 10 low bits", b[13:0], 14'h3c00);
  endtask

  task automatic t_break_hold();
    logic [31:0] b1, b2;
    align();
    brk_req = 1'b1;
    collect(15, b1);
    brk_req = 1'b0;
    collect(10, b2);
    check(b1[14:0] == 15'h0000, "R8 held break low first 15", b1[14:0], 0);
    check(b2[9:0] == 10'h3e0, "R8 two breaks then idle", b2[9:0], 10'h3e0);
  endtask

  task automatic t_te_done();
    logic [31:0] b;
    align();
    tx_en = 1'b0;
    @(negedge clk);
    pulse_rd();
    tx_en = 1'b1;
    @(negedge clk);
    check(tx_done == 1'b0, "R5 enable rise clears done", tx_done, 0);
    collect(13, b);
    check(b[12:0] == 13'h1fff, "R9 preamble high", b[12:0], 13'h1fff);
    check(tx_done == 1'b1, "R5 done after preamble", tx_done, 1);
  endtask

  task automatic t_disabled_order();
    logic [31:0] b, e;
    align();
    tx_en = 1'b0;
    @(negedge clk);
    pulse_rd();
    pulse_wr(9'h00F);
    pulse_brk();
    collect(12, b);
    check(b[11:0] == 12'hfff, "R10 line high while disabled", b[11:0], 12'hfff);
    check(buf_empty == 1'b0, "R10 data still pending", buf_empty, 0);
    tx_en = 1'b1;
    collect(30, b);
    e = exp_frame(9'h00F, 1'b0);
    check(b[9:0] == 10'h3ff, "R9 preamble first", b[9:0], 10'h3ff);
    check(b[19:10] == 10'h000, "R9 break second", b[19:10], 0);
    check(b[29:20] == e[9:0], "R9 data last", b[29:20], e[9:0]);
    check(buf_empty == 1'b1, "R4 empty after queued data sent", buf_empty, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    t_reset();
    t_unarmed_write();
    t_send8();
    t_send9();
    t_arm_rule();
    t_break_single();
    t_break_hold();
    t_te_done();
    t_disabled_order();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule